// File: doc/BRIEF.md
# Column-Counting 16x16 Unsigned Multiplier

This block multiplies two 16-bit unsigned operands and presents the full 32-bit product without a clock. It works column by column in the vertical-and-crosswise manner: for every weight k it gathers all AND terms `a[i] & b[j]` with `i + j = k`, adds the carry bits handed forward by earlier columns, and counts the ones. The count's lowest bit becomes product bit k, and each higher count bit d is forwarded to column k + d.

Each column count is produced by a bit-counting compressor sized in steps of five inputs (5, 10, 15 or 20). The compressor is built from 5-input counters whose small results are summed. Unused compressor inputs are tied low. The widest column, weight 15, carries 16 AND terms plus four forwarded carries and so fills a 20-input compressor.

The block sits in a datapath as a purely combinational stage. Any registering is left to the surrounding logic.

Top module: `vx_mul16`

## Requirements
- R1: `data_out` equals the unsigned product `a * b`, all 32 bits, for every operand pair.
- R2: Product bit 0 equals `a[0] & b[0]`, with no carry entering column 0.
- R3: For single-bit operands `a = 1 << i` and `b = 1 << j`, exactly one product bit is set, at position `i + j`. This confirms that each AND term lands in column `i + j`.
- R4: `16'hFFFF * 16'hFFFF` yields `32'hFFFE0001`, the heaviest load that every column can see.
- R5: When either operand is zero the product is zero, whatever the other operand holds.
- R6: `3 * 7` yields 21 and `3 * 3` yields 9.
- R7: Bit 31 is formed only from carries forwarded into the top column. No column forwards a nonzero count bit beyond weight 31. For example, `16'hFFFF * 16'h8001` yields `32'h80007FFF`, with bit 31 set.
- R8: Every compressor output equals the number of ones on its inputs. A 5-input counter reports 0 to 5, and a tiered compressor reports the sum of its groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | Unsigned multiplier operand |
| b | input | 16 | Unsigned multiplicand operand |
| data_out | output | 32 | Unsigned product of a and b |

## Verification
The embedded checks assume that both operands are stable, known 2-state values whenever they are evaluated. They also assume that every carry a column receives comes only from the four columns below it, so a wider carry span would break the compressor sizing. The stimulus holds each operand pair steady for a full bench period before sampling. It covers walking single bits, all-ones and zero operands, a dense sweep of small operands against a set of edge multiplicands, and 10,000 pseudo-random pairs whose expected products are computed by plain multiplication in the bench.

// File: rtl/vx_mul_pkg.sv
package vx_mul_pkg;
  // Inputs handled by one elementary counter.
  localparam int GROUP_W = 5;
  // Largest compressor tier, in elementary groups (20 inputs).
  localparam int MAX_GROUPS = 4;

  // Number of AND terms of weight k for two n-bit operands.
  function automatic int ppCount(input int k, input int n);
    if (k < 0 || k > 2 * n - 2) return 0;
    return (k < n) ? k + 1 : 2 * n - 1 - k;
  endfunction

  // Lowest multiplier index present in column k.
  function automatic int ppOffset(input int k, input int n);
    return (k < n) ? 0 : k - n + 1;
  endfunction

  // Compressor tier (groups of GROUP_W) for a given input count.
  function automatic int tierGroups(input int inputs);
    int g;
    g = (inputs + GROUP_W - 1) / GROUP_W;
    if (g < 1) g = 1;
    return g;
  endfunction
endpackage

// File: rtl/vx_count5.sv
module vx_count5 (
  input  logic [4:0] bitsIn,
  output logic [2:0] onesCnt
);
  always_comb begin
    onesCnt = 3'(bitsIn[0]) + 3'(bitsIn[1]) + 3'(bitsIn[2])
            + 3'(bitsIn[3]) + 3'(bitsIn[4]);
  end

  // R8
  always_comb begin
    count5_ones_chk: assert (32'(onesCnt) == $countones(bitsIn))
      else $error("5-input counter mismatch");
  end
endmodule

// File: rtl/vx_compressor.sv
module vx_compressor #(
  parameter int GROUPS = 1,
  parameter int CNT_W  = 5,
  localparam int IN_W  = GROUPS * vx_mul_pkg::GROUP_W
) (
  input  logic [IN_W-1:0]  colBits,
  output logic [CNT_W-1:0] colCount
);
  logic [2:0] groupCnt [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : grpGen
    vx_count5 u_cnt (
      .bitsIn  (colBits[g*5 +: 5]),
      .onesCnt (groupCnt[g])
    );
  end

  always_comb begin
    colCount = '0;
    for (int g = 0; g < GROUPS; g++) begin
      colCount = colCount + CNT_W'(groupCnt[g]);
    end
  end

  // R8
  always_comb begin
    tier_ones_chk: assert (32'(colCount) == $countones(colBits))
      else $error("compressor tier count mismatch");
  end
endmodule

// File: rtl/vx_mul16.sv
module vx_mul16 #(
  parameter int N     = 16,
  parameter int CNT_W = 5,
  localparam int COLS = 2 * N,
  localparam int CARRY_SLOTS = CNT_W - 1
) (
  input  logic [N-1:0]    a,
  input  logic [N-1:0]    b,
  output logic [COLS-1:0] data_out
);
  import vx_mul_pkg::*;

  logic [COLS-1:0] spillBits;

  for (genvar k = 0; k < COLS; k++) begin : colGen
    localparam int PP  = ppCount(k, N);
    localparam int OFF = ppOffset(k, N);
    localparam int GRP = tierGroups(PP + CARRY_SLOTS);
    localparam int IW  = GRP * GROUP_W;

    logic [IW-1:0]    colIn;
    logic [CNT_W-1:0] cnt;

    for (genvar s = 0; s < IW; s++) begin : slotGen
      if (s < PP) begin : ppSlot
        assign colIn[s] = a[s + OFF] & b[k - s - OFF];
      end else if (s < PP + CARRY_SLOTS) begin : carrySlot
        localparam int D = s - PP + 1;
        if (k - D >= 0) begin : fromBelow
          assign colIn[s] = colGen[k - D].cnt[D];
        end else begin : noSource
          assign colIn[s] = 1'b0;
        end
      end else begin : padSlot
        assign colIn[s] = 1'b0;
      end
    end

    vx_compressor #(
      .GROUPS (GRP),
      .CNT_W  (CNT_W)
    ) u_comp (
      .colBits  (colIn),
      .colCount (cnt)
    );

    assign data_out[k] = cnt[0];

    if (k + CARRY_SLOTS > COLS - 1) begin : spillGen
      assign spillBits[k] = |cnt[CNT_W-1 : COLS-k];
    end else begin : noSpill
      assign spillBits[k] = 1'b0;
    end
  end

  // R7
  always_comb begin
    no_spill_chk: assert (spillBits == '0)
      else $error("carry forwarded beyond the top column");
  end

  // R2
  always_comb begin
    lsb_term_chk: assert (data_out[0] == (a[0] & b[0]))
      else $error("bit 0 is not a0 AND b0");
  end

  // R1
  always_comb begin
    full_product_chk: assert (data_out == COLS'(COLS'(a) * COLS'(b)))
      else $error("product mismatch");
  end
endmodule

// File: tb/vx_mul16_tb.sv
module vx_mul16_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic [31:0] data_out;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vx_mul16 u_dut (
    .a        (a),
    .b        (b),
    .data_out (data_out)
  );

  task automatic apply(input logic [15:0] x, input logic [15:0] y);
    a = x;
    b = y;
    #(CLK_PERIOD);
  endtask

  task automatic expect32(input string req, input logic [31:0] got, input logic [31:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s a=%h b=%h got=%h expected=%h", req, a, b, got, want);
    end
  endtask

  task automatic mulCheck(input string req, input logic [15:0] x, input logic [15:0] y);
    apply(x, y);
    expect32(req, data_out, 32'(x) * 32'(y));
  endtask

  initial begin
    logic [15:0] edges [8];
    edges = '{16'h0000, 16'h0001, 16'h0002, 16'h00FF, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF};
    #(CLK_PERIOD/2);

    // R5: reset-free quiescent state, zero inputs give zero
    apply(16'h0000, 16'h0000);
    expect32("R5", data_out, 32'h0);
    apply(16'h0000, 16'hFFFF);
    expect32("R5", data_out, 32'h0);
    apply(16'hA5C3, 16'h0000);
    expect32("R5", data_out, 32'h0);

    // R6: small worked products
    apply(16'd3, 16'd7);
    expect32("R6", data_out, 32'd21);
    apply(16'd3, 16'd3);
    expect32("R6", data_out, 32'd9);

    // R4: all-ones operands
    apply(16'hFFFF, 16'hFFFF);
    expect32("R4", data_out, 32'hFFFE0001);

    // R7: top bit from forwarded carries only
    apply(16'hFFFF, 16'h8001);
    expect32("R7", data_out, 32'h80007FFF);
    apply(16'h8000, 16'h8000);
    expect32("R7", data_out, 32'h40000000);

    // R3: walking single bits land in column i+j
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        apply(16'(1) << i, 16'(1) << j);
        expect32("R3", data_out, 32'(1) << (i + j));
      end
    end

    // R2: bit 0 tracks a0 AND b0 over all four combinations
    for (int p = 0; p < 4; p++) begin
      apply({15'h2B3A, p[0]}, {15'h1C47, p[1]});
      expect32("R2", {31'b0, data_out[0]}, {31'b0, p[0] & p[1]});
    end

    // R1: dense sweep of small operands against edge values
    for (int x = 0; x < 256; x++) begin
      for (int e = 0; e < 8; e++) begin
        mulCheck("R1", 16'(x), edges[e]);
      end
    end

    // R1: pseudo-random pairs
    for (int r = 0; r < 10000; r++) begin
      mulCheck("R1", 16'($urandom), 16'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule